// File: doc/BRIEF.md
# Multi-destination ticket vending controller

This block is the sequencing core of a coin-operated ticket vendor. A passenger first picks one of three destinations, each with its own fixed fare, and then feeds coins worth 1, 2 or 5 units. The controller keeps a registered running total. Once the total reaches or passes the chosen fare, it raises a one-cycle ticket pulse and presents the excess as change during that same cycle. A cancel request while coins are being collected gives one refund cycle instead, in which the whole total appears on the change output. After either kind of ending, the controller clears itself and waits for the next destination.

The running total only changes on a clock edge. Adding a coin therefore never creates a combinational feedback path, and the sum saturates at the largest value the total width can hold. Coin checking, mechanical dispensing and display driving are done elsewhere.

Top module: `ticket_vend`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) returns the controller to the idle state, with ticket 0, change 0 and total 0, even when a transaction is in progress.
- R2: In idle, a destination strobe (dest_stb bit 0, 1 or 2) selects a fare of 3, 4 or 6 units and starts coin collection with a total of 0. If several bits are high in the same cycle, the lowest index is taken.
- R3: During collection, a coin strobe (coin_stb bit 0 = 1 unit, bit 1 = 2 units, bit 2 = 5 units) adds its value to total, visible after the next rising edge. If several bits are high in the same cycle, only the lowest value is added.
- R4: When the new total equals the fare, the next cycle shows ticket = 1 and change = 0 for exactly one cycle.
- R5: When the new total exceeds the fare, the ticket cycle shows change = total − fare.
- R6: The cycle after a ticket or refund cycle is idle again, with ticket = 0, change = 0 and total = 0, and a new destination is accepted.
- R7: Cancel during collection gives one refund cycle with ticket = 0 and change = total. Cancel wins over a coin strobe in the same cycle, and that coin is not added.
- R8: In idle, coin strobes and cancel have no effect: total and change stay 0 and no ticket is issued.
- R9: Destination strobes outside idle are ignored, so the fare chosen at the start of the transaction stays in force.
- R10: The sum of total and a coin saturates at the largest value of the total width (15 for 4 bits) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dest_stb | input | 3 | Destination select strobes, bit n picks destination n |
| coin_stb | input | 3 | Coin strobes: bit0 = 1, bit1 = 2, bit2 = 5 units |
| cancel | input | 1 | Abort the current transaction and refund |
| ticket | output | 1 | One-cycle ticket issue pulse |
| change | output | W | Change on a ticket cycle, full refund on a refund cycle, 0 otherwise |
| total | output | W | Registered running coin total |

## Verification
The saturation path is the hardest case to reach: with the default fares, the total can never get above 10, so the sum never gets close to wrapping. The bench adds a second instance with a first fare of 14. It feeds that instance coins up to 13 and then a 5-unit coin, and expects the ticket cycle to show a total of 15 and change of 1. A second subtle case is a late destination strobe that would lower the fare. The bench sends one during collection and then shows that a total equal to the lower fare does not issue a ticket.

// File: rtl/ticket_vend.sv
module ticket_vend #(
  parameter int W     = 4,
  parameter int FARE0 = 3,
  parameter int FARE1 = 4,
  parameter int FARE2 = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   dest_stb,
  input  logic [2:0]   coin_stb,
  input  logic         cancel,
  output logic         ticket,
  output logic [W-1:0] change,
  output logic [W-1:0] total
);

  localparam logic [1:0] S_IDLE    = 2'd0;
  localparam logic [1:0] S_COLLECT = 2'd1;
  localparam logic [1:0] S_VEND    = 2'd2;
  localparam logic [1:0] S_REFUND  = 2'd3;

  localparam logic [W-1:0] F0   = W'(FARE0);
  localparam logic [W-1:0] F1   = W'(FARE1);
  localparam logic [W-1:0] F2   = W'(FARE2);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [1:0]   state_q;
  logic [W-1:0] total_q;
  logic [W-1:0] fare_q;
  logic [W-1:0] coin_val;
  logic [W-1:0] fare_pick;
  logic [W:0]   sum_wide;
  logic [W-1:0] sum_sat;

  assign coin_val  = coin_stb[0] ? W'(1) :
                     coin_stb[1] ? W'(2) :
                     coin_stb[2] ? W'(5) : '0;
  assign fare_pick = dest_stb[0] ? F0 : dest_stb[1] ? F1 : F2;
  assign sum_wide  = {1'b0, total_q} + {1'b0, coin_val};
  assign sum_sat   = sum_wide[W] ? MAXV : sum_wide[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      total_q <= '0;
      fare_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          total_q <= '0;
          if (|dest_stb) begin
            fare_q  <= fare_pick;
            state_q <= S_COLLECT;
          end
        end
        S_COLLECT: begin
          if (cancel) begin
            state_q <= S_REFUND;
          end else if (|coin_stb) begin
            total_q <= sum_sat;
            if (sum_sat >= fare_q) state_q <= S_VEND;
          end
        end
        default: begin
          state_q <= S_IDLE;
          total_q <= '0;
        end
      endcase
    end
  end

  assign ticket = (state_q == S_VEND);
  assign change = (state_q == S_VEND)   ? total_q - fare_q :
                  (state_q == S_REFUND) ? total_q : '0;
  assign total  = total_q;

endmodule

// File: rtl/ticket_vend_chk.sv
module ticket_vend_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   coin_stb,
  input logic         cancel,
  input logic         ticket,
  input logic [W-1:0] change,
  input logic [W-1:0] total,
  input logic [1:0]   state_q
);

  localparam logic [1:0] S_IDLE    = 2'd0;
  localparam logic [1:0] S_COLLECT = 2'd1;
  localparam logic [1:0] S_REFUND  = 2'd3;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ticket && change == '0 && total == '0));

  a_r4_ticket_single: assert property (@(posedge clk) disable iff (rst)
    ticket |=> !ticket);

  a_r6_clear_after_end: assert property (@(posedge clk) disable iff (rst)
    (ticket || state_q == S_REFUND) |=> (state_q == S_IDLE && total == '0 && change == '0));

  a_r7_cancel_refunds: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_COLLECT && cancel) |=> (state_q == S_REFUND && !ticket && change == $past(total)));

  a_r8_idle_coin_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && |coin_stb) |=> (total == '0 && !ticket));

  a_r10_total_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_COLLECT && !cancel && |coin_stb) |=> (total > $past(total)
                                                        || total == {W{1'b1}}));

endmodule

bind ticket_vend ticket_vend_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .coin_stb(coin_stb), .cancel(cancel),
  .ticket(ticket), .change(change), .total(total), .state_q(state_q)
);

// File: tb/ticket_vend_test.sv
module ticket_vend_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] dest_stb = '0;
  logic [2:0] coin_stb = '0;
  logic       cancel = 1'b0;
  logic       ticket, ticket_s;
  logic [3:0] change, total, change_s, total_s;

  int total_n = 0;
  int bad_n   = 0;

  always #4 clk = ~clk;

  ticket_vend uut (
    .clk(clk), .rst(rst), .dest_stb(dest_stb), .coin_stb(coin_stb),
    .cancel(cancel), .ticket(ticket), .change(change), .total(total)
  );

  ticket_vend #(.FARE0(14)) uut_sat (
    .clk(clk), .rst(rst), .dest_stb(dest_stb), .coin_stb(coin_stb),
    .cancel(cancel), .ticket(ticket_s), .change(change_s), .total(total_s)
  );

  // {dest, coin, cancel, exp_ticket, exp_change, exp_total}
  localparam int NV = 23;
  localparam logic [15:0] VEC [NV] = '{
    {3'b001, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R2 fare 3
    {3'b000, 3'b001, 1'b0, 1'b0, 4'd0, 4'd1},  // R3
    {3'b000, 3'b010, 1'b0, 1'b1, 4'd0, 4'd3},  // R4 exact
    {3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R6
    {3'b010, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R2 fare 4
    {3'b000, 3'b100, 1'b0, 1'b1, 4'd1, 4'd5},  // R5
    {3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R6
    {3'b100, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R2 fare 6
    {3'b000, 3'b110, 1'b0, 1'b0, 4'd0, 4'd2},  // R3 lowest of 2,5
    {3'b000, 3'b011, 1'b0, 1'b0, 4'd0, 4'd3},  // R3 lowest of 1,2
    {3'b000, 3'b100, 1'b0, 1'b1, 4'd2, 4'd8},  // R5
    {3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R6
    {3'b000, 3'b100, 1'b0, 1'b0, 4'd0, 4'd0},  // R8 coin in idle
    {3'b000, 3'b000, 1'b1, 1'b0, 4'd0, 4'd0},  // R8 cancel in idle
    {3'b110, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R2 lowest index -> fare 4
    {3'b001, 3'b010, 1'b0, 1'b0, 4'd0, 4'd2},  // R9 late strobe
    {3'b000, 3'b001, 1'b0, 1'b0, 4'd0, 4'd3},  // R9 still fare 4
    {3'b000, 3'b100, 1'b1, 1'b0, 4'd3, 4'd3},  // R7 cancel beats coin
    {3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R6 after refund
    {3'b100, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0},  // R2 fare 6
    {3'b000, 3'b100, 1'b0, 1'b0, 4'd0, 4'd5},  // R3
    {3'b000, 3'b001, 1'b0, 1'b1, 4'd0, 4'd6},  // R4 exact
    {3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 4'd0}   // R6
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] d, input logic [2:0] c, input logic x);
    dest_stb = d; coin_stb = c; cancel = x;
    @(posedge clk);
    @(negedge clk);
    dest_stb = '0; coin_stb = '0; cancel = 1'b0;
  endtask

  initial begin
    #1500000;
    total_n++; bad_n++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 ticket", {3'b0, ticket}, 4'd0);
    check("R1 change", change, 4'd0);
    check("R1 total", total, 4'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:13], VEC[i][12:10], VEC[i][9]);
      check($sformatf("vec%0d ticket", i), {3'b0, ticket}, {3'b0, VEC[i][8]});
      check($sformatf("vec%0d change", i), change, VEC[i][7:4]);
      check($sformatf("vec%0d total", i), total, VEC[i][3:0]);
    end

    // R1: reset mid-transaction
    step(3'b001, 3'b000, 1'b0);
    step(3'b000, 3'b010, 1'b0);
    check("R1 pre total", total, 4'd2);
    rst = 1'b1;
    step(3'b000, 3'b000, 1'b0);
    rst = 1'b0;
    check("R1 mid total", total, 4'd0);
    check("R1 mid change", change, 4'd0);
    step(3'b000, 3'b010, 1'b0);
    check("R1 back in idle", total, 4'd0);

    // R10: saturation on uut_sat (fare 14)
    step(3'b001, 3'b000, 1'b0);
    step(3'b000, 3'b100, 1'b0);
    step(3'b000, 3'b100, 1'b0);
    step(3'b000, 3'b010, 1'b0);
    check("R10 pre", total_s, 4'd12);
    step(3'b000, 3'b001, 1'b0);
    check("R10 13", total_s, 4'd13);
    step(3'b000, 3'b100, 1'b0);
    check("R10 sat total", total_s, 4'd15);
    check("R10 ticket", {3'b0, ticket_s}, 4'd1);
    check("R10 change", change_s, 4'd1);
    step(3'b000, 3'b000, 1'b0);
    check("R6 sat cleared", total_s, 4'd0);

    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

endmodule